// File: doc/BRIEF.md
# Masked Interrupt Status Controller

This block collects the interrupt causes of a packet-based Ethernet controller into one 8-bit status byte. It combines that byte with an 8-bit enable byte to drive a single level-sensitive interrupt line. Event sources raise single-cycle set pulses, one per status bit. Two status bits are also held high by live queue conditions: the transmit queue is empty, and the transmit completion queue holds entries. While either condition lasts, its bit cannot stay cleared.

Software clears causes by writing an acknowledge byte. Only a fixed subset of bits responds to it. Writing the acknowledge byte with the transmit-complete bit set also sends a one-cycle pop request to the completion queue. Software enables causes by writing the mask byte. The interrupt line is registered and follows the status and mask bytes on the same clock edge that updates them.

Bit positions are fixed, from bit 7 down to bit 0:

| Bit | Cause |
| --- | --- |
| 7 | management |
| 6 | early receive |
| 5 | PHY/link event |
| 4 | receive overrun |
| 3 | allocation done |
| 2 | transmit empty |
| 1 | transmit complete |
| 0 | receive |

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset the status byte is 0x04, the mask byte is 0x00, and both the interrupt line and the pop pulse are low.
- R2: A set pulse on bit b makes status bit b read 1 after the next clock edge. The bit then stays 1 until an acknowledge clears it.
- R3: An acknowledge write clears, at the next edge, every written 1 that lies in bits 7, 6, 4, 2 or 1 (clear mask 0xD6).
- R4: An acknowledge write has no effect on bits 5, 3 and 0. These bits never fall while out of reset.
- R5: While the transmit-empty input is high, status bit 2 reads 1 after every edge, even directly after an acknowledge of bit 2.
- R6: While the completion-queue-non-empty input is high, status bit 1 reads 1 after every edge, even directly after an acknowledge of bit 1.
- R7: A set pulse on a bit in the same cycle as an acknowledge of that bit leaves the bit set.
- R8: A mask write loads the written byte into the mask at the next edge. Without a write, the mask holds its value.
- R9: After every edge, the interrupt line equals the OR of (status AND mask). A mask write therefore changes the line on the same edge that changes the mask.
- R10: The pop pulse is high for exactly the one cycle that follows an acknowledge write with bit 1 set, and low otherwise.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| evt_set_i | input | 8 | Per-bit set pulses from the event sources |
| txq_empty_i | input | 1 | Live condition: transmit queue length is zero |
| done_avail_i | input | 1 | Live condition: completion queue is non-empty |
| ack_we_i | input | 1 | Acknowledge byte write strobe |
| ack_data_i | input | 8 | Acknowledge byte; a 1 requests a clear |
| mask_we_i | input | 1 | Mask byte write strobe |
| mask_data_i | input | 8 | New mask byte |
| status_o | output | 8 | Interrupt status byte |
| mask_o | output | 8 | Interrupt mask byte |
| irq_o | output | 1 | Level interrupt request |
| done_pop_o | output | 1 | One-cycle request to drop the head of the completion queue |

## Verification
The hardest cases are the collisions within a single cycle. One is a set pulse or a live condition arriving together with an acknowledge of the same bit. Another is an acknowledge of bit 1 while the completion queue is still non-empty: the pop must fire, but the bit must stay set. Directed steps drive each collision on purpose, with the expected byte worked out by hand. A long random phase then drives sparse set pulses, acknowledges and mask writes together with toggling live inputs. A behavioural reference model checks every output on every cycle of that phase.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned IRQ_W = 8;
  typedef logic [IRQ_W-1:0] irq_vec_t;
  localparam int unsigned BIT_TXE  = 2;
  localparam int unsigned BIT_DONE = 1;
  localparam irq_vec_t ACK_CLR_MASK = 8'hD6;
  localparam irq_vec_t STATUS_RST   = 8'h04;
  localparam irq_vec_t MASK_RST     = 8'h00;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
  import irq_pkg::*;
#(
  parameter int unsigned W         = IRQ_W,
  parameter logic [W-1:0] CLR_MASK = ACK_CLR_MASK,
  parameter logic [W-1:0] RST_VAL  = STATUS_RST
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] live_i,
  input  logic         ack_we_i,
  input  logic [W-1:0] ack_data_i,
  output logic [W-1:0] status_d_o,
  output logic [W-1:0] status_q_o
);
  logic [W-1:0] stat_q;
  logic [W-1:0] stat_d;

  for (genvar b = 0; b < W; b++) begin : g_bit
    if (CLR_MASK[b]) begin : g_clr
      // clearable bit: set and live conditions win over a same-cycle clear
      always_comb begin
        stat_d[b] = set_i[b] | live_i[b] |
                    (stat_q[b] & ~(ack_we_i & ack_data_i[b]));
      end
    end else begin : g_sticky
      always_comb begin
        stat_d[b] = set_i[b] | live_i[b] | stat_q[b];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q[b] <= RST_VAL[b];
      else        stat_q[b] <= stat_d[b];
    end
  end

  assign status_d_o = stat_d;
  assign status_q_o = stat_q;
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
  import irq_pkg::*;
#(
  parameter int unsigned W        = IRQ_W,
  parameter logic [W-1:0] RST_VAL = MASK_RST
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] mask_d_o,
  output logic [W-1:0] mask_q_o
);
  logic [W-1:0] msk_q;
  logic [W-1:0] msk_d;

  always_comb begin
    msk_d = msk_q;
    if (we_i) msk_d = data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    msk_q <= RST_VAL;
    else if (we_i) msk_q <= msk_d;
  end

  assign mask_d_o = msk_d;
  assign mask_q_o = msk_q;
endmodule

// File: rtl/irq_out_gen.sv
module irq_out_gen
  import irq_pkg::*;
#(
  parameter int unsigned W        = IRQ_W,
  parameter int unsigned POP_BIT  = BIT_DONE
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] status_d_i,
  input  logic [W-1:0] mask_d_i,
  input  logic         ack_we_i,
  input  logic [W-1:0] ack_data_i,
  output logic         irq_o,
  output logic         pop_o
);
  logic irq_q, irq_d;
  logic pop_q, pop_d;

  always_comb begin
    irq_d = |(status_d_i & mask_d_i);
    pop_d = ack_we_i & ack_data_i[POP_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      pop_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
      pop_q <= pop_d;
    end
  end

  assign irq_o = irq_q;
  assign pop_o = pop_q;
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned W         = IRQ_W,
  parameter int unsigned TXE_POS   = BIT_TXE,
  parameter int unsigned DONE_POS  = BIT_DONE,
  parameter logic [W-1:0] CLR_MASK = ACK_CLR_MASK,
  parameter int unsigned SYNC_STG  = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_set_i,
  input  logic         txq_empty_i,
  input  logic         done_avail_i,
  input  logic         ack_we_i,
  input  logic [W-1:0] ack_data_i,
  input  logic         mask_we_i,
  input  logic [W-1:0] mask_data_i,
  output logic [W-1:0] status_o,
  output logic [W-1:0] mask_o,
  output logic         irq_o,
  output logic         done_pop_o
);
  logic         rst_sync_n;
  logic [W-1:0] live_vec;
  logic [W-1:0] status_d, mask_d;

  always_comb begin
    live_vec           = '0;
    live_vec[TXE_POS]  = txq_empty_i;
    live_vec[DONE_POS] = done_avail_i;
  end

  irq_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  irq_status_reg #(.W(W), .CLR_MASK(CLR_MASK), .RST_VAL(STATUS_RST)) u_stat (
    .clk(clk), .rst_n(rst_sync_n), .set_i(evt_set_i), .live_i(live_vec),
    .ack_we_i(ack_we_i), .ack_data_i(ack_data_i),
    .status_d_o(status_d), .status_q_o(status_o)
  );

  irq_mask_reg #(.W(W), .RST_VAL(MASK_RST)) u_mask (
    .clk(clk), .rst_n(rst_sync_n), .we_i(mask_we_i), .data_i(mask_data_i),
    .mask_d_o(mask_d), .mask_q_o(mask_o)
  );

  irq_out_gen #(.W(W), .POP_BIT(DONE_POS)) u_out (
    .clk(clk), .rst_n(rst_sync_n), .status_d_i(status_d), .mask_d_i(mask_d),
    .ack_we_i(ack_we_i), .ack_data_i(ack_data_i),
    .irq_o(irq_o), .pop_o(done_pop_o)
  );
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk (
  input logic       clk,
  input logic       rst_ok,
  input logic [7:0] evt_set_i,
  input logic       txq_empty_i,
  input logic       done_avail_i,
  input logic       ack_we_i,
  input logic [7:0] ack_data_i,
  input logic       mask_we_i,
  input logic [7:0] mask_data_i,
  input logic [7:0] status_o,
  input logic [7:0] mask_o,
  input logic       irq_o,
  input logic       done_pop_o
);
  // R2
  set_bits_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    1'b1 |=> ((status_o & $past(evt_set_i)) == $past(evt_set_i)));
  // R3
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    ack_we_i |=> ((status_o & $past(ack_data_i & 8'hD6 & ~evt_set_i &
                   ~{5'b0, txq_empty_i, done_avail_i, 1'b0})) == 8'h00));
  // R4
  sticky_bits_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    1'b1 |=> ((status_o & $past(status_o) & 8'h29) == ($past(status_o) & 8'h29)));
  // R5
  txe_live_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    txq_empty_i |=> status_o[2]);
  // R6
  done_live_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    done_avail_i |=> status_o[1]);
  // R8
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    mask_we_i |=> (mask_o == $past(mask_data_i)));
  // R8
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !mask_we_i |=> $stable(mask_o));
  // R9
  irq_level_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    irq_o == |(status_o & mask_o));
  // R10
  pop_fire_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (ack_we_i && ack_data_i[1]) |=> done_pop_o);
  // R10
  pop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !(ack_we_i && ack_data_i[1]) |=> !done_pop_o);
endmodule

bind irq_status_ctrl irq_status_chk u_chk (
  .clk(clk), .rst_ok(rst_sync_n), .evt_set_i(evt_set_i),
  .txq_empty_i(txq_empty_i), .done_avail_i(done_avail_i),
  .ack_we_i(ack_we_i), .ack_data_i(ack_data_i), .mask_we_i(mask_we_i),
  .mask_data_i(mask_data_i), .status_o(status_o), .mask_o(mask_o),
  .irq_o(irq_o), .done_pop_o(done_pop_o)
);

// File: tb/irq_status_ctrl_bench.sv
module irq_status_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] evt_set = 8'h00;
  logic       txq_empty = 1'b1;
  logic       done_avail = 1'b0;
  logic       ack_we = 1'b0;
  logic [7:0] ack_data = 8'h00;
  logic       mask_we = 1'b0;
  logic [7:0] mask_data = 8'h00;
  logic [7:0] status_o, mask_o;
  logic       irq_o, done_pop_o;

  int checks = 0;
  int errors = 0;
  bit model_on = 0;
  bit finished = 0;
  int m_status, m_mask, m_irq, m_pop;

  always #4 clk = ~clk;

  irq_status_ctrl u_irq_status_ctrl (
    .clk(clk), .rst_n(rst_n), .evt_set_i(evt_set), .txq_empty_i(txq_empty),
    .done_avail_i(done_avail), .ack_we_i(ack_we), .ack_data_i(ack_data),
    .mask_we_i(mask_we), .mask_data_i(mask_data), .status_o(status_o),
    .mask_o(mask_o), .irq_o(irq_o), .done_pop_o(done_pop_o)
  );

  // behavioural reference, written from the requirements
  always @(posedge clk) begin
    if (model_on) begin
      int clr;
      clr = ack_we ? (ack_data & 'hD6) : 0;
      m_status = (m_status & ~clr) | evt_set;
      if (txq_empty)  m_status = m_status | 'h04;
      if (done_avail) m_status = m_status | 'h02;
      if (mask_we) m_mask = mask_data;
      m_irq = ((m_status & m_mask) != 0) ? 1 : 0;
      m_pop = (ack_we && ack_data[1]) ? 1 : 0;
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    check("R2 R3 R4 R5 R6 R7 model status", status_o, m_status);
    check("R8 model mask", mask_o, m_mask);
    check("R9 model irq", irq_o, m_irq);
    check("R10 model pop", done_pop_o, m_pop);
    evt_set = 8'h00; ack_we = 1'b0; ack_data = 8'h00; mask_we = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    m_status = 'h04; m_mask = 0; m_irq = 0; m_pop = 0;
    model_on = 1;
    // R1 reset state
    check("R1 status", status_o, 'h04);
    check("R1 mask", mask_o, 'h00);
    check("R1 irq", irq_o, 0);
    check("R1 pop", done_pop_o, 0);
    // R2 set pulses latch
    evt_set = 8'h21; step();
    check("R2 status", status_o, 'h25);
    // R4 ack all bits, only clear-mask bits drop
    txq_empty = 1'b0; ack_we = 1'b1; ack_data = 8'hFF; step();
    check("R4 status", status_o, 'h21);
    step();
    check("R4 held", status_o, 'h21);
    // R8 / R9 mask write raises irq on same edge
    mask_we = 1'b1; mask_data = 8'h01; step();
    check("R8 mask", mask_o, 'h01);
    check("R9 irq", irq_o, 1);
    // R7 set beats same-cycle ack
    evt_set = 8'h80; ack_we = 1'b1; ack_data = 8'h80; step();
    check("R7 status", status_o, 'hA1);
    // R3 plain ack of bit 7
    ack_we = 1'b1; ack_data = 8'h80; step();
    check("R3 status", status_o, 'h21);
    // R6 live completion condition
    done_avail = 1'b1; step();
    check("R6 status", status_o, 'h23);
    ack_we = 1'b1; ack_data = 8'h02; step();
    check("R6 after ack", status_o, 'h23);
    check("R10 pop", done_pop_o, 1);
    done_avail = 1'b0; ack_we = 1'b1; ack_data = 8'h02; step();
    check("R3 done cleared", status_o, 'h21);
    check("R10 pop again", done_pop_o, 1);
    step();
    check("R10 pop low", done_pop_o, 0);
    // R5 live transmit-empty condition
    txq_empty = 1'b1; step();
    check("R5 status", status_o, 'h25);
    ack_we = 1'b1; ack_data = 8'h04; step();
    check("R5 after ack", status_o, 'h25);
    // R9 masking
    mask_we = 1'b1; mask_data = 8'h08; step();
    check("R9 irq masked", irq_o, 0);
    evt_set = 8'h08; step();
    check("R9 irq enabled", irq_o, 1);
    // random phase against the model
    for (int i = 0; i < 3000; i++) begin
      evt_set    = (($urandom % 4) == 0) ? 8'($urandom) & 8'($urandom) : 8'h00;
      txq_empty  = ($urandom % 3) == 0;
      done_avail = ($urandom % 3) == 0;
      ack_we     = ($urandom % 3) == 0;
      ack_data   = 8'($urandom);
      mask_we    = ($urandom % 8) == 0;
      mask_data  = 8'($urandom);
      step();
    end
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule